// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, one destination address at a time, whether a frame is kept. A 48-bit address arrives with a one-cycle strobe. It is compared in parallel against sixteen exact-match slots. Slot 0 is normally the station's own unicast address; the other slots usually hold group addresses. An address that hits no slot is handled in one of three ways. The all-ones broadcast address is governed by its own enable bit. A group address, meaning bit 0 of the first byte is set, is tested against a 4096-bit hash table. Any other address is dropped.

Software programs the slots, the hash table and a small control word through a flat write port with a combinational read-back. To set one hash bit, software reads the 32-bit table word, ORs in the bit and writes the word back. The 12-bit hash index is a window over the last two address bytes, and the control word picks one of four window positions. The verdict appears one clock after the strobe. It says whether the frame is accepted and which of exact, broadcast or hash caused it, and for an exact hit it also gives the slot number.

A two-state lookup sequencer drives the result valid flag. It has two states:

- `LK_IDLE`: no result is shown.
- `LK_SHOW`: a result is shown for the strobe of the previous cycle.

Its transitions are:

- `LK_IDLE -> LK_SHOW` when the strobe is high.
- `LK_SHOW -> LK_SHOW` when strobes arrive back to back.
- `LK_SHOW -> LK_IDLE` when the strobe is low.
- `LK_IDLE -> LK_IDLE` when the strobe stays low.

Top module: `dest_addr_filter`

## Requirements
- R1: A slot whose valid flag is set and whose 48 stored bits equal the looked-up address gives accept with the exact flag set, and `res_idx` carries the lowest such slot number. When the exact flag is clear, `res_idx` is 0.
- R2: A slot whose valid flag is clear never matches, whatever address it stores. Writing zero to both of its words disables it.
- R3: Slot n sits at config address 2n (low word) and 2n+1 (high word), with the address byte 0 in `lk_addr[7:0]`. The low word holds address bits 31:0. The high word holds address bits 47:32 in bits 15:0 and the valid flag in bit 31, and its other bits read as 0.
- R4: The hash index depends on the mode held in control bits 1:0. Mode 0 is `{b5, b4[7:4]}`, mode 1 is `{b5[6:0], b4[7:3]}`, mode 2 is `{b5[5:0], b4[7:2]}` and mode 3 is `{b5[3:0], b4}`. Here b4 is `lk_addr[39:32]` and b5 is `lk_addr[47:40]`. No other address bits affect the index.
- R5: Hash table word w sits at config address 0x80+w. Index bits 11:5 pick the word and bits 4:0 pick the bit within it. Words read back what was written.
- R6: The hash table is consulted only when `lk_addr[0]` is 1. An address that has this bit at 0 and hits no slot is rejected.
- R7: The all-ones address that hits no slot is accepted with the broadcast flag exactly when control bit 2 (at config address 0x40) is 1. Otherwise it is rejected and the hash table is not consulted.
- R8: Each strobe yields exactly one result, with `res_valid` high in the cycle after the strobe. Without a strobe, `res_valid` stays low.
- R9: After reset every slot is invalid, every hash word and the control word read 0, and all result outputs are low.
- R10: The exact match takes priority over broadcast and hash. At most one kind flag is high, and `res_accept` equals the OR of the three kind flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config word address (slots, control 0x40, hash words 0x80-0xFF) |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Combinational read-back of the word at `cfg_addr` |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_exact | output | 1 | Accepted by an exact slot |
| res_bcast | output | 1 | Accepted as broadcast |
| res_hash | output | 1 | Accepted through the hash table |
| res_idx | output | 4 | Matching slot number on an exact hit |

## Verification
The bound checker watches several rules on every cycle:

- the one-cycle strobe-to-result timing and the absence of results without a strobe;
- the exclusivity of the kind flags and their agreement with accept;
- a zero slot number outside exact hits;
- the rule that unicast and all-ones addresses never produce a hash hit.

Which address is accepted, and for which reason, depends on programmed contents, so only the bench scenarios show it. They cover:

- the register layout and read-back;
- invalid and cleared slots;
- lowest-slot priority;
- each of the four hash windows with literal word and bit positions;
- the broadcast enable;
- precedence of exact hits over broadcast and hash.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;

    localparam int MAC_W  = 48;
    localparam int HASH_W = 12;

    typedef enum logic [1:0] {
        HM_HI4  = 2'd0,
        HM_HI3  = 2'd1,
        HM_HI2  = 2'd2,
        HM_FULL = 2'd3
    } hash_mode_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_EXACT = 2'd1,
        KIND_BCAST = 2'd2,
        KIND_HASH  = 2'd3
    } match_kind_e;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_SHOW = 1'b1
    } lk_state_e;

    // 12-bit index window over the last two address bytes
    function automatic logic [HASH_W-1:0] hash_window(input hash_mode_e mode,
                                                      input logic [7:0] b4,
                                                      input logic [7:0] b5);
        logic [HASH_W-1:0] h;
        unique case (mode)
            HM_HI4:  h = {b5,      b4[7:4]};
            HM_HI3:  h = {b5[6:0], b4[7:3]};
            HM_HI2:  h = {b5[5:0], b4[7:2]};
            HM_FULL: h = {b5[3:0], b4};
            default: h = '0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/daf_exact_cam.sv
`timescale 1ns/1ps
module daf_exact_cam #(
    parameter int N_ENTRY = 16,
    parameter int IDX_W   = $clog2(N_ENTRY),
    parameter int MAC_W   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_high,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_high,
    output logic [31:0]      rd_data,
    input  logic [MAC_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    localparam int LO_W    = 32;
    localparam int HI_W    = MAC_W - LO_W;
    localparam int VLD_BIT = 31;
    localparam int PAD_W   = VLD_BIT - HI_W;

    logic [MAC_W-1:0]   ent_addr [N_ENTRY];
    logic [N_ENTRY-1:0] ent_vld;
    logic [N_ENTRY-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) begin
                ent_addr[i] <= '0;
            end
            ent_vld <= '0;
        end else if (wr_en) begin
            if (wr_high) begin
                ent_addr[wr_idx][MAC_W-1:LO_W] <= wdata[HI_W-1:0];
                ent_vld[wr_idx]                <= wdata[VLD_BIT];
            end else begin
                ent_addr[wr_idx][LO_W-1:0] <= wdata;
            end
        end
    end

    // one comparator per slot
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_addr[g] == key);
    end

    // lowest slot wins
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (rd_high) begin
            rd_data = {ent_vld[rd_idx], {PAD_W{1'b0}}, ent_addr[rd_idx][MAC_W-1:LO_W]};
        end else begin
            rd_data = ent_addr[rd_idx][LO_W-1:0];
        end
    end

endmodule

// File: rtl/daf_hash_table.sv
`timescale 1ns/1ps
module daf_hash_table #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    parameter int WSEL_W = $clog2(WORDS),
    parameter int BSEL_W = $clog2(WORD_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WSEL_W-1:0]        wr_word,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [WSEL_W-1:0]        rd_word,
    output logic [WORD_W-1:0]        rd_data,
    input  logic [WSEL_W+BSEL_W-1:0] probe,
    output logic                     probe_bit
);
    logic [WORD_W-1:0] tbl [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_word] <= wdata;
        end
    end

    assign rd_data   = tbl[rd_word];
    assign probe_bit = tbl[probe[WSEL_W+BSEL_W-1:BSEL_W]][probe[BSEL_W-1:0]];

endmodule

// File: rtl/daf_decide.sv
`timescale 1ns/1ps
module daf_decide
    import daf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [MAC_W-1:0] key,
    input  logic             exact_hit,
    input  logic [IDX_W-1:0] exact_idx,
    input  logic             hash_bit,
    input  logic             bcast_en,
    output logic             accept,
    output match_kind_e      kind,
    output logic [IDX_W-1:0] idx
);
    logic is_bcast;
    logic is_group;

    assign is_bcast = &key;
    assign is_group = key[0];

    always_comb begin
        kind = KIND_NONE;
        idx  = '0;
        if (exact_hit) begin
            kind = KIND_EXACT;
            idx  = exact_idx;
        end else if (is_bcast) begin
            if (bcast_en) begin
                kind = KIND_BCAST;
            end
        end else if (is_group && hash_bit) begin
            kind = KIND_HASH;
        end
        accept = (kind != KIND_NONE);
    end

endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int N_ENTRY    = 16,
    parameter int HASH_WORDS = 128,
    parameter int HASH_WORD  = 32,
    parameter int CFG_AW     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    input  logic                       lk_valid,
    input  logic [MAC_W-1:0]           lk_addr,
    output logic                       res_valid,
    output logic                       res_accept,
    output logic                       res_exact,
    output logic                       res_bcast,
    output logic                       res_hash,
    output logic [$clog2(N_ENTRY)-1:0] res_idx
);
    localparam int IDX_W   = $clog2(N_ENTRY);
    localparam int WSEL_W  = $clog2(HASH_WORDS);
    localparam int BSEL_W  = $clog2(HASH_WORD);
    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(1 << (IDX_W + 2));
    localparam int BCAST_BIT = 2;

    // ---------------- config decode ----------------
    logic sel_ent, sel_ctrl, sel_hash;
    assign sel_ent  = (cfg_addr[CFG_AW-1:IDX_W+1] == '0);
    assign sel_ctrl = (cfg_addr == CTRL_ADDR);
    assign sel_hash = cfg_addr[CFG_AW-1];

    hash_mode_e mode_q;
    logic       bcast_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= HM_HI4;
            bcast_q <= 1'b0;
        end else if (cfg_wr && sel_ctrl) begin
            mode_q  <= hash_mode_e'(cfg_wdata[1:0]);
            bcast_q <= cfg_wdata[BCAST_BIT];
        end
    end

    // ---------------- exact slots ----------------
    logic [31:0]      cam_rd;
    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;

    daf_exact_cam #(
        .N_ENTRY (N_ENTRY),
        .IDX_W   (IDX_W),
        .MAC_W   (MAC_W)
    ) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr && sel_ent),
        .wr_idx  (cfg_addr[IDX_W:1]),
        .wr_high (cfg_addr[0]),
        .wdata   (cfg_wdata),
        .rd_idx  (cfg_addr[IDX_W:1]),
        .rd_high (cfg_addr[0]),
        .rd_data (cam_rd),
        .key     (lk_addr),
        .hit     (cam_hit),
        .hit_idx (cam_idx)
    );

    // ---------------- hash table ----------------
    logic [HASH_W-1:0]    hidx;
    logic [HASH_WORD-1:0] tbl_rd;
    logic                 tbl_bit;

    assign hidx = hash_window(mode_q, lk_addr[39:32], lk_addr[47:40]);

    daf_hash_table #(
        .WORDS  (HASH_WORDS),
        .WORD_W (HASH_WORD),
        .WSEL_W (WSEL_W),
        .BSEL_W (BSEL_W)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr && sel_hash),
        .wr_word   (cfg_addr[WSEL_W-1:0]),
        .wdata     (cfg_wdata),
        .rd_word   (cfg_addr[WSEL_W-1:0]),
        .rd_data   (tbl_rd),
        .probe     (hidx),
        .probe_bit (tbl_bit)
    );

    always_comb begin
        if (sel_hash) begin
            cfg_rdata = tbl_rd;
        end else if (sel_ent) begin
            cfg_rdata = cam_rd;
        end else if (sel_ctrl) begin
            cfg_rdata = {29'b0, bcast_q, mode_q};
        end else begin
            cfg_rdata = '0;
        end
    end

    // ---------------- decision ----------------
    logic             dec_accept;
    match_kind_e      dec_kind;
    logic [IDX_W-1:0] dec_idx;

    daf_decide #(
        .IDX_W (IDX_W)
    ) u_dec (
        .key       (lk_addr),
        .exact_hit (cam_hit),
        .exact_idx (cam_idx),
        .hash_bit  (tbl_bit),
        .bcast_en  (bcast_q),
        .accept    (dec_accept),
        .kind      (dec_kind),
        .idx       (dec_idx)
    );

    // ---------------- lookup sequencer ----------------
    lk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LK_IDLE: state_d = lk_valid ? LK_SHOW : LK_IDLE;
            LK_SHOW: state_d = lk_valid ? LK_SHOW : LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    match_kind_e      kind_q;
    logic             acc_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_NONE;
            acc_q  <= 1'b0;
            idx_q  <= '0;
        end else if (lk_valid) begin
            kind_q <= dec_kind;
            acc_q  <= dec_accept;
            idx_q  <= dec_idx;
        end else begin
            kind_q <= KIND_NONE;
            acc_q  <= 1'b0;
            idx_q  <= '0;
        end
    end

    assign res_valid  = (state_q == LK_SHOW);
    assign res_accept = res_valid && acc_q;
    assign res_exact  = res_valid && (kind_q == KIND_EXACT);
    assign res_bcast  = res_valid && (kind_q == KIND_BCAST);
    assign res_hash   = res_valid && (kind_q == KIND_HASH);
    assign res_idx    = res_valid ? idx_q : '0;

endmodule

// File: rtl/daf_sva.sv
`timescale 1ns/1ps
module daf_sva #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [47:0]      lk_addr,
    input logic             res_valid,
    input logic             res_accept,
    input logic             res_exact,
    input logic             res_bcast,
    input logic             res_hash,
    input logic [IDX_W-1:0] res_idx
);
    AST_STROBE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);                                                   // R8
    AST_NO_STROBE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);                                                 // R8
    AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_accept);                                               // R8
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_exact, res_bcast, res_hash}));                               // R10
    AST_ACCEPT_IS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept == (res_exact || res_bcast || res_hash));                       // R10
    AST_IDX_ZERO_OFF_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_exact |-> (res_idx == '0));                                           // R1
    AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_addr[0]) |=> !res_hash);                                  // R6
    AST_BCAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (&lk_addr)) |=> !res_hash);                                   // R7
endmodule

bind dest_addr_filter daf_sva #(.IDX_W($clog2(N_ENTRY))) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_exact  (res_exact),
    .res_bcast  (res_bcast),
    .res_hash   (res_hash),
    .res_idx    (res_idx)
);

// File: tb/dest_addr_filter_test.sv
`timescale 1ns/1ps
module dest_addr_filter_test;
    localparam int         NENT  = 16;
    localparam int         NWORD = 128;
    localparam logic [7:0] CTRL  = 8'h40;
    localparam logic [7:0] HBASE = 8'h80;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        res_valid, res_accept, res_exact, res_bcast, res_hash;
    logic [3:0]  res_idx;

    dest_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .res_valid(res_valid), .res_accept(res_accept),
        .res_exact(res_exact), .res_bcast(res_bcast), .res_hash(res_hash),
        .res_idx(res_idx)
    );

    always #2.5 clk = ~clk;

    int     checks = 0;
    int     fails = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference state kept by the bench
    logic [47:0] m_addr [NENT];
    bit          m_vld  [NENT];
    logic [31:0] m_tbl  [NWORD];
    int          m_mode = 0;
    bit          m_bc = 1'b0;

    // scoreboard: {accept, exact, bcast, hash, idx[3:0]}
    logic [7:0] exp_q[$];
    string      req_q[$];
    longint     due_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int bhash(input logic [47:0] a, input int mode);
        int s;
        int b4;
        int b5;
        b4 = int'(a[39:32]);
        b5 = int'(a[47:40]);
        case (mode)
            0: s = 4;
            1: s = 3;
            2: s = 2;
            default: s = 0;
        endcase
        return ((b4 >> s) | (b5 << (8 - s))) & 'hFFF;
    endfunction

    function automatic logic [7:0] predict(input logic [47:0] a);
        for (int i = 0; i < NENT; i++) begin
            if (m_vld[i] && m_addr[i] == a) return {4'b1100, 4'(i)};
        end
        if (&a) return m_bc ? 8'b1010_0000 : 8'h00;
        if (a[0]) begin
            int h;
            h = bhash(a, m_mode);
            if (m_tbl[h >> 5][h & 31]) return 8'b1001_0000;
        end
        return 8'h00;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "result without strobe", 1, 0);
            end else begin
                logic [7:0] e;
                string      r;
                longint     d;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                d = due_q.pop_front();
                check(cyc == d, "R8", "result cycle", 64'(cyc), 64'(d));
                check({res_accept, res_exact, res_bcast, res_hash, res_idx} == e, r,
                      "verdict", {res_accept, res_exact, res_bcast, res_hash, res_idx}, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        lk_valid  = 1'b0;
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < 8'd32) begin
            if (a[0]) begin
                m_addr[a >> 1][47:32] = d[15:0];
                m_vld[a >> 1]         = d[31];
            end else begin
                m_addr[a >> 1][31:0] = d;
            end
        end else if (a == CTRL) begin
            m_mode = int'(d[1:0]);
            m_bc   = d[2];
        end else if (a[7]) begin
            m_tbl[a[6:0]] = d;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        lk_valid = 1'b0;
        cfg_wr   = 1'b0;
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic look(input logic [47:0] a, input string req);
        @(negedge clk);
        cfg_wr   = 1'b0;
        lk_valid = 1'b1;
        lk_addr  = a;
        exp_q.push_back(predict(a));
        req_q.push_back(req);
        due_q.push_back(cyc + 1);
    endtask

    task automatic quiet(input int n);
        @(negedge clk);
        lk_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_entry(input int i, input logic [47:0] a, input bit v);
        wr(8'(2 * i), a[31:0]);
        wr(8'(2 * i + 1), {v, 15'b0, a[47:32]});
    endtask

    task automatic set_hash_bit(input logic [47:0] a);
        int h;
        logic [31:0] w;
        h = bhash(a, m_mode);
        rd(HBASE + 8'(h >> 5), w);
        wr(HBASE + 8'(h >> 5), w | (32'h1 << (h & 31)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [47:0] a0, a1, m5, mh, mh2;
        int h;
        a0  = 48'h0A0B_0C0D_0E02;
        a1  = 48'h1234_5678_9A04;
        m5  = 48'h6655_4433_2201;
        mh  = 48'hA7C3_0000_5E01;
        mh2 = 48'hA7D3_0000_5E01;
        for (int i = 0; i < NENT; i++) begin
            m_addr[i] = '0;
            m_vld[i]  = 1'b0;
        end
        for (int i = 0; i < NWORD; i++) m_tbl[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check(res_valid == 1'b0 && res_accept == 1'b0, "R9", "outputs after reset",
              {res_valid, res_accept}, 0);
        rd(CTRL, d);          check(d == 32'h0, "R9", "control word", d, 0);
        rd(8'h01, d);         check(d == 32'h0, "R9", "slot 0 high word", d, 0);
        rd(HBASE + 8'd127, d); check(d == 32'h0, "R9", "hash word 127", d, 0);
        look(BC, "R9");
        look(48'h0, "R2");
        quiet(2);

        // R1, R3: slot 0 and layout
        put_entry(0, a0, 1'b1);
        rd(8'h00, d); check(d == 32'h0C0D_0E02, "R3", "slot low word", d, 32'h0C0D_0E02);
        rd(8'h01, d); check(d == 32'h8000_0A0B, "R3", "slot high word", d, 32'h8000_0A0B);
        look(a0, "R1");
        look(a0 ^ 48'h1000_0000_0000, "R1");
        quiet(1);

        // R2: valid flag and clearing
        put_entry(5, m5, 1'b0);
        look(m5, "R2");
        put_entry(5, m5, 1'b1);
        look(m5, "R1");
        wr(8'd10, 32'h0);
        wr(8'd11, 32'h0);
        look(m5, "R2");
        rd(8'd11, d); check(d == 32'h0, "R2", "cleared high word", d, 0);

        // R1: lowest slot wins
        put_entry(7, a1, 1'b1);
        put_entry(3, a1, 1'b1);
        look(a1, "R1");
        wr(8'd7, 32'h0);
        look(a1, "R1");
        quiet(1);

        // R4: every window mode
        for (int m = 0; m < 4; m++) begin
            wr(CTRL, 32'(m));
            set_hash_bit(mh);
            look(mh, "R4");
            look(mh ^ 48'h0000_0000_0100, "R4");
            look(mh ^ 48'h0080_0000_0000, "R4");
            h = bhash(mh, m);
            wr(HBASE + 8'(h >> 5), 32'h0);
        end

        // R5: literal word/bit positions in mode 0
        wr(CTRL, 32'h0);
        set_hash_bit(mh);
        rd(HBASE + 8'h53, d); check(d == 32'h1000_0000, "R5", "word 0x53 after first bit", d, 32'h1000_0000);
        set_hash_bit(mh2);
        rd(HBASE + 8'h53, d); check(d == 32'h3000_0000, "R5", "word 0x53 after second bit", d, 32'h3000_0000);
        look(mh2, "R5");
        wr(CTRL, 32'h3);
        look(mh, "R4");
        wr(CTRL, 32'h0);

        // R6: unicast with a set hash bit
        look(mh & ~48'h1, "R6");

        // R7: broadcast enable
        wr(HBASE + 8'd127, 32'h8000_0000);
        look(BC, "R7");
        wr(CTRL, 32'h4);
        rd(CTRL, d); check(d == 32'h4, "R7", "control read-back", d, 32'h4);
        look(BC, "R7");
        quiet(1);

        // R10: precedence
        put_entry(9, BC, 1'b1);
        look(BC, "R10");
        put_entry(12, mh, 1'b1);
        look(mh, "R10");

        // R8: back to back, then idle
        look(a0, "R8");
        look(mh2, "R8");
        look(48'h0000_0000_0001, "R8");
        quiet(5);
        check(exp_q.size() == 0, "R8", "pending results", 64'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule